// File: doc/BRIEF.md
# Wrapping Sample Readout Address Generator

This block sequences byte-serial host reads from a 15-bit sample SRAM. A host places the block in readout mode and pulses an active-low strobe once per byte. While the strobe is low, the block drives the byte at the current read pointer. When the strobe returns high, the pointer moves forward by one. Entering readout mode always sends the pointer back to the base of the extracted-sample region at 0x4000. Reads past the top of the address space wrap back to that base, not to zero.

The extracted region is laid out as follows:

- Two 500-byte sample subsets sit back to back from 0x4000.
- A fixed three-byte signature follows them.
- After the signature comes a 100-byte mirror of part of the second subset.

A host that reads 1003 bytes can therefore compare the last three against the signature and detect a corrupted transfer. The SRAM is modelled inside the block. It holds only the 1000 sample bytes, which are filled through a simple load port. Every other location is decoded from the address.

Top module: `sram_readout_seq`

## Requirements
- R1: While reset is asserted, and right after it, the pointer `rd_addr` equals 0x4000 and `rd_data` is 0x00 with the strobe high. Asserting reset takes effect at once, even in the middle of a strobe.
- R2: A rising edge of `rd_mode`, as seen at a clock edge, loads the pointer with 0x4000 on that edge. This holds even when a strobe rise occurs in the same cycle.
- R3: `rd_data` carries the byte at the pointer only while `rd_mode` is high and `strobe_n` is low. Otherwise it is 0x00.
- R4: In readout mode, a low-to-high transition of `strobe_n` (low at one clock edge, high at the next) advances the pointer by exactly one on the second edge. A strobe while `rd_mode` is low leaves the pointer unchanged.
- R5: Advancing from 0x7FFF gives 0x4000.
- R6: Addresses 0x4000 to 0x43E7 return the loaded sample byte at index (address - 0x4000). Sample index k is written by `ld_en` with `ld_idx`=k and `ld_data`.
- R7: Addresses 0x43E8, 0x43E9 and 0x43EA return 0x01, 0xFE and 0x80, so the last three bytes of a 1003-byte read form that signature.
- R8: Addresses 0x43EB to 0x444E return the sample byte at index 800 + (address - 0x43EB).
- R9: Addresses from 0x444F to 0x7FFF return 0x00.
- R10: With no strobe rise and no mode entry, the pointer holds its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rd_mode | input | 1 | High while readout mode is selected; its rise restarts the pointer |
| strobe_n | input | 1 | Active-low host byte strobe, synchronous to clk |
| ld_en | input | 1 | Write enable for the sample store |
| ld_idx | input | 10 | Sample index to write (0 to 999) |
| ld_data | input | 8 | Sample byte to write |
| rd_addr | output | 15 | Current read pointer |
| rd_data | output | 8 | Byte at the pointer while strobed in readout mode, else 0x00 |

## Verification
The bench loads a computed sample pattern and sweeps the whole 16384-byte readout window one strobe at a time. It checks the pointer and the byte at every address, so an off-by-one at any region boundary shows up as a wrong byte. A design that wraps to zero, or fails to wrap at all, is caught by the read after 0x7FFF. An error in the mirror offset corrupts the bytes just past the signature. The bench also covers four further cases:

- a strobe while out of readout mode, which a faulty design would let advance the pointer;
- a mode entry that coincides with a strobe rise, which must not land one byte past the base;
- a re-entry in the middle of a read;
- a reset asserted while the strobe is low.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  typedef logic [7:0] byte_t;

  localparam int unsigned SIG_LEN = 3;

  // Integrity marker appended after the two sample subsets.
  function automatic byte_t sig_byte(input logic [1:0] k);
    case (k)
      2'd0:    sig_byte = 8'h01;
      2'd1:    sig_byte = 8'hFE;
      default: sig_byte = 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/rdo_edge.sv
module rdo_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_mode,
  input  logic strobe_n,
  output logic entry,
  output logic adv
);

  logic strb_q, strb_d;
  logic mode_q, mode_d;

  always_comb begin
    strb_d = strobe_n;
    mode_d = rd_mode;
    entry  = rd_mode & ~mode_q;
    adv    = rd_mode & mode_q & ~strb_q & strobe_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      strb_q <= strb_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/rdo_ptr.sv
module rdo_ptr #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned BASE   = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] TOP_A  = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_en = entry | adv;
    ptr_d  = ptr;
    if (entry) begin
      ptr_d = BASE_A;
    end else if (adv) begin
      ptr_d = (ptr == TOP_A) ? BASE_A : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= BASE_A;
    end else if (ptr_en) begin
      ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/rdo_map.sv
module rdo_map
  import rdo_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned BASE    = 16384,
  parameter int unsigned SUB_LEN = 500,
  parameter int unsigned MIR_LEN = 100,
  parameter int unsigned MIR_SRC = 800,
  parameter int unsigned IDX_W   = 10
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  byte_t             ld_data,
  input  logic [ADDR_W-1:0] addr,
  output byte_t             byte_o
);

  localparam int unsigned SMP_LEN = 2 * SUB_LEN;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] SIG_A  = ADDR_W'(BASE + SMP_LEN);
  localparam logic [ADDR_W-1:0] MIR_A  = ADDR_W'(BASE + SMP_LEN + SIG_LEN);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE + SMP_LEN + SIG_LEN + MIR_LEN);

  byte_t mem [SMP_LEN];

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] off;

  always_ff @(posedge clk) begin
    if (ld_en && (32'(ld_idx) < SMP_LEN)) begin
      mem[ld_idx] <= ld_data;
    end
  end

  always_comb begin
    byte_o = '0;
    idx    = '0;
    off    = '0;
    if (addr >= BASE_A && addr < SIG_A) begin
      off    = addr - BASE_A;
      idx    = off[IDX_W-1:0];
      byte_o = mem[idx];
    end else if (addr >= SIG_A && addr < MIR_A) begin
      off    = addr - SIG_A;
      byte_o = sig_byte(off[1:0]);
    end else if (addr >= MIR_A && addr < END_A) begin
      off    = addr - MIR_A;
      idx    = IDX_W'(MIR_SRC) + off[IDX_W-1:0];
      byte_o = mem[idx];
    end
  end

endmodule

// File: rtl/sram_readout_seq.sv
module sram_readout_seq
  import rdo_pkg::*;
#(
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned BASE        = 16384,
  parameter int unsigned SUB_LEN     = 500,
  parameter int unsigned MIR_LEN     = 100,
  parameter int unsigned MIR_SRC     = 800,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_mode,
  input  logic              strobe_n,
  input  logic              ld_en,
  input  logic [9:0]        ld_idx,
  input  logic [7:0]        ld_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int unsigned IDX_W = 10;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_s;
  logic                   entry, adv;
  byte_t                  map_byte;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end
  endgenerate

  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  rdo_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_mode  (rd_mode),
    .strobe_n (strobe_n),
    .entry    (entry),
    .adv      (adv)
  );

  rdo_ptr #(.ADDR_W(ADDR_W), .BASE(BASE)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n_s),
    .entry (entry),
    .adv   (adv),
    .ptr   (rd_addr)
  );

  rdo_map #(
    .ADDR_W(ADDR_W), .BASE(BASE), .SUB_LEN(SUB_LEN),
    .MIR_LEN(MIR_LEN), .MIR_SRC(MIR_SRC), .IDX_W(IDX_W)
  ) u_map (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .addr    (rd_addr),
    .byte_o  (map_byte)
  );

  always_comb begin
    rd_data = (rd_mode && !strobe_n) ? map_byte : 8'h00;
  end

endmodule

// File: rtl/sram_readout_chk.sv
module sram_readout_chk #(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned BASE    = 16384,
  parameter int unsigned SUB_LEN = 500
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              rd_mode,
  input logic              strobe_n,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [7:0]        rd_data
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] TOP_A  = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SIG_A  = ADDR_W'(BASE + 2 * SUB_LEN);

  logic prev_strb, prev_mode;
  logic c_adv, c_entry;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      prev_strb <= 1'b1;
      prev_mode <= 1'b0;
    end else begin
      prev_strb <= strobe_n;
      prev_mode <= rd_mode;
    end
  end

  assign c_entry = rd_mode && !prev_mode;
  assign c_adv   = rd_mode && prev_mode && !prev_strb && strobe_n;

  a_r2_entry_base: assert property (@(posedge clk) disable iff (!rst_ns)
    c_entry |=> rd_addr == BASE_A);

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_adv && rd_addr != TOP_A) |=> rd_addr == $past(rd_addr) + 1'b1);

  a_r5_wrap_base: assert property (@(posedge clk) disable iff (!rst_ns)
    (c_adv && rd_addr == TOP_A) |=> rd_addr == BASE_A);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!c_adv && !c_entry) |=> $stable(rd_addr));

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    (strobe_n || !rd_mode) |-> rd_data == 8'h00);

  a_r7_sig_first: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_mode && !strobe_n && rd_addr == SIG_A) |-> rd_data == 8'h01);

  a_r1_base_floor: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_addr >= BASE_A);

endmodule

bind sram_readout_seq sram_readout_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .SUB_LEN(SUB_LEN)
) u_chk (
  .clk      (clk),
  .rst_ns   (rst_n_s),
  .rd_mode  (rd_mode),
  .strobe_n (strobe_n),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data)
);

// File: tb/tb_sram_readout_seq.sv
module tb_sram_readout_seq;

  logic        clk = 1'b0;
  logic        rst_n, rd_mode, strobe_n, ld_en;
  logic [9:0]  ld_idx;
  logic [7:0]  ld_data;
  logic [14:0] rd_addr;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_readout_seq dut (
    .clk(clk), .rst_n(rst_n), .rd_mode(rd_mode), .strobe_n(strobe_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] samp(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] exp_byte(int a);
    if (a >= 16384 && a < 17384) return samp(a - 16384);
    if (a == 17384) return 8'h01;
    if (a == 17385) return 8'hFE;
    if (a == 17386) return 8'h80;
    if (a >= 17387 && a < 17487) return samp(800 + a - 17387);
    return 8'h00;
  endfunction

  function automatic string req_of(int a);
    if (a < 17384) return "R6";
    if (a < 17387) return "R7";
    if (a < 17487) return "R8";
    return "R9";
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_one(output logic [7:0] b, output logic [14:0] a);
    @(negedge clk) strobe_n = 1'b0;
    @(negedge clk);
    a = rd_addr;
    b = rd_data;
    strobe_n = 1'b1;
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [14:0] a;
    logic [7:0]  last3 [3];

    rst_n = 1'b0; rd_mode = 1'b0; strobe_n = 1'b1;
    ld_en = 1'b0; ld_idx = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", int'(rd_addr), 16'h4000);
    chk("R1", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", int'(rd_addr), 16'h4000);

    for (int k = 0; k < 1000; k++) begin
      ld_en = 1'b1; ld_idx = 10'(k); ld_data = samp(k);
      @(negedge clk);
    end
    ld_en = 1'b0;

    // R3 / R4: strobe outside readout mode
    strobe_n = 1'b0;
    @(negedge clk);
    chk("R3", int'(rd_data), 0);
    strobe_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4", int'(rd_addr), 16'h4000);

    // R2: enter readout mode
    rd_mode = 1'b1;
    @(negedge clk);
    chk("R2", int'(rd_addr), 16'h4000);
    chk("R3", int'(rd_data), 0);
    repeat (5) @(negedge clk);
    chk("R10", int'(rd_addr), 16'h4000);

    // Full sweep of the readout window
    for (int i = 0; i < 16384; i++) begin
      rd_one(b, a);
      chk("R4", int'(a), 16384 + i);
      chk(req_of(16384 + i), int'(b), int'(exp_byte(16384 + i)));
      if (i >= 1000 && i < 1003) last3[i - 1000] = b;
    end
    chk("R7", {8'h0, last3[0], last3[1], last3[2]}, 32'h0001FE80);
    @(negedge clk);
    chk("R5", int'(rd_addr), 16'h4000);
    rd_one(b, a);
    chk("R5", int'(b), int'(samp(0)));

    // R10: idle hold
    repeat (6) @(negedge clk);
    chk("R10", int'(rd_addr), 16'h4001);

    // R2: entry coinciding with strobe rise
    for (int i = 0; i < 4; i++) rd_one(b, a);
    @(negedge clk) rd_mode = 1'b0;
    @(negedge clk) strobe_n = 1'b0;
    @(negedge clk);
    chk("R3", int'(rd_data), 0);
    rd_mode = 1'b1; strobe_n = 1'b1;
    @(negedge clk);
    chk("R2", int'(rd_addr), 16'h4000);

    // R2: re-entry mid-read
    for (int i = 0; i < 3; i++) rd_one(b, a);
    @(negedge clk);
    chk("R4", int'(rd_addr), 16'h4003);
    rd_mode = 1'b0;
    @(negedge clk) rd_mode = 1'b1;
    @(negedge clk);
    chk("R2", int'(rd_addr), 16'h4000);
    rd_one(b, a);
    chk("R6", int'(b), int'(samp(0)));

    // R1: reset while strobe is low
    for (int i = 0; i < 2; i++) rd_one(b, a);
    @(negedge clk) strobe_n = 1'b0;
    @(negedge clk);
    chk("R4", int'(rd_addr), 16'h4003);
    rst_n = 1'b0;
    #1;
    chk("R1", int'(rd_addr), 16'h4000);
    @(negedge clk) strobe_n = 1'b1; rd_mode = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", int'(rd_addr), 16'h4000);
    chk("R1", int'(rd_data), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule